// File: doc/BRIEF.md
# Shaped BPSK31 Audio Sample Generator

This block turns a stream of symbol bits into 8-bit audio samples that carry a 31.25 baud binary phase-shift-keyed signal on a 1 kHz tone. An external strobe `tick` marks each 31.25 us sample period (32 kHz). Every 1024 ticks form one symbol window. A window for a reversal bit (0) lowers the amplitude smoothly to zero, flips the carrier polarity at that minimum, and raises the amplitude again. A window for a no-reversal bit (1) holds the tone at full amplitude with the polarity unchanged.

Bits enter through a valid/ready pair and are taken only on the last tick of a window. If no bit is offered there, the block inserts a reversal, so an idle link sends the usual stream of reversals. The carrier is built from a 32-step sine sampled at half-step offsets. Because of that offset the falling half of a window is exactly the rising half played backwards, and the tone stays phase-continuous through every ramp. Each output sample is offset binary, with 0x80 meaning zero amplitude, and is flagged by a one-cycle strobe.

Top module: `bpsk31_shaper`

## Requirements
- R1: After reset `sample_out` is 0x80, `sample_strobe` and `bit_ready` are low, the polarity is positive, the window position is 0 and the current bit is a reversal (0).
- R2: Each cycle with `tick` high is followed in the next cycle by exactly one cycle of `sample_strobe`, with the new sample on `sample_out`. Without a tick there is no strobe and `sample_out` keeps its value.
- R3: The sample for carrier step i = (tick count since reset) mod 32 is 0x80 + floor(p/128 + 0.5), where p = e * s(i) * (-1 if the polarity is negative), s(i) = round(127*sin(2*pi*(i+0.5)/32)), and e is the envelope value.
- R4: A window lasts 1024 ticks, numbered 0 to 1023. `bit_ready` is high only while `tick` is high at position 1023. A bit is taken only in that cycle and governs the next window.
- R5: In a reversal window, at position m < 512 the envelope is e(15 - m/32) and at m >= 512 it is e((m-512)/32), using integer division, where e(k) = round(128*sin^2(pi*(k+0.5)/32)). The polarity toggles between positions 511 and 512, and the sample at position 511 is 0x80.
- R6: In a no-reversal window (bit 1) the envelope is 128 for all 1024 positions and the polarity does not change.
- R7: If `bit_valid` is low at the accepting tick, the next window is a reversal window.
- R8: Within a reversal window, the sample at position m equals the sample at position 1023 - m, so the ramp-down is the following ramp-up played in reverse.
- R9: The carrier step count and the polarity carry across window boundaries without a jump, including runs of no-reversal windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-period strobe, one cycle wide |
| bit_valid | input | 1 | A symbol bit is offered |
| bit_data | input | 1 | Symbol bit: 0 = reversal, 1 = no reversal |
| bit_ready | output | 1 | Bit taken in this cycle (last tick of a window) |
| sample_out | output | 8 | Offset-binary audio sample, 0x80 = zero |
| sample_strobe | output | 1 | New sample on `sample_out` |

## Verification
Each sample is registered on the clock edge that samples `tick`. The strobe and the new value are therefore due one cycle after the tick, and the bench reads them on the falling edge that follows that rising edge. `bit_ready` is combinational from `tick` and the window position, so the bench reads it in the tick cycle itself, before the edge. A polarity toggle requested at position 511 first shows in the sample for position 512. The bench's own model advances its position, bit and polarity only after it has compared each sample, so every check uses the state in force when the tick was seen.

// File: rtl/bpsk31_pkg.sv
package bpsk31_pkg;
  localparam int STEP_LOG2 = 5;                       // 32 carrier steps
  localparam int RAMP_LOG2 = 4;                       // 16 carrier cycles per ramp
  localparam int WIN_LOG2  = STEP_LOG2 + RAMP_LOG2 + 1;
  localparam int SAMPLE_W  = 8;
  localparam int ENV_W     = 8;
  localparam int ENV_SHIFT = 7;
  localparam logic [ENV_W-1:0] ENV_FULL = ENV_W'(1 << ENV_SHIFT);
  localparam int PROD_W    = 2 * SAMPLE_W + 1;

  // First quarter of the half-step-offset sine, amplitude 127
  function automatic logic [SAMPLE_W-1:0] sine_quarter(input logic [2:0] q);
    case (q)
      3'd0: sine_quarter = 8'd12;
      3'd1: sine_quarter = 8'd37;
      3'd2: sine_quarter = 8'd60;
      3'd3: sine_quarter = 8'd81;
      3'd4: sine_quarter = 8'd98;
      3'd5: sine_quarter = 8'd112;
      3'd6: sine_quarter = 8'd122;
      default: sine_quarter = 8'd126;
    endcase
  endfunction

  // Signed sine for a 32-step index, built from quarter symmetry
  function automatic logic signed [SAMPLE_W-1:0] sine_at(input logic [STEP_LOG2-1:0] i);
    logic [2:0] q;
    logic [SAMPLE_W-1:0] mag;
    q   = i[3] ? ~i[2:0] : i[2:0];
    mag = sine_quarter(q);
    sine_at = i[4] ? -$signed(mag) : $signed(mag);
  endfunction

  // Raised-cosine envelope level per carrier cycle, 0..128
  function automatic logic [ENV_W-1:0] env_at(input logic [RAMP_LOG2-1:0] k);
    case (k)
      4'd0:  env_at = 8'd0;
      4'd1:  env_at = 8'd3;
      4'd2:  env_at = 8'd8;
      4'd3:  env_at = 8'd15;
      4'd4:  env_at = 8'd23;
      4'd5:  env_at = 8'd34;
      4'd6:  env_at = 8'd45;
      4'd7:  env_at = 8'd58;
      4'd8:  env_at = 8'd70;
      4'd9:  env_at = 8'd83;
      4'd10: env_at = 8'd94;
      4'd11: env_at = 8'd105;
      4'd12: env_at = 8'd113;
      4'd13: env_at = 8'd120;
      4'd14: env_at = 8'd125;
      default: env_at = 8'd128;
    endcase
  endfunction

  // Scale a signed sine by the envelope, round half up, offset to 0x80
  function automatic logic [SAMPLE_W-1:0] mix(input logic [ENV_W-1:0] env,
                                              input logic signed [SAMPLE_W-1:0] s,
                                              input logic neg);
    logic signed [SAMPLE_W:0] sv;
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] r;
    sv = neg ? -$signed({s[SAMPLE_W-1], s}) : $signed({s[SAMPLE_W-1], s});
    p  = $signed({{(PROD_W-ENV_W){1'b0}}, env}) *
         $signed({{(PROD_W-SAMPLE_W-1){sv[SAMPLE_W]}}, sv});
    r  = (p + PROD_W'(1 << (ENV_SHIFT-1))) >>> ENV_SHIFT;
    mix = r[SAMPLE_W-1:0] + SAMPLE_W'(1 << (SAMPLE_W-1));
  endfunction
endpackage

// File: rtl/bpsk31_window_timer.sv
module bpsk31_window_timer
  import bpsk31_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  output logic [WIN_LOG2-1:0] pos,
  output logic                at_mid,
  output logic                at_end
);
  localparam logic [WIN_LOG2-1:0] MID_POS = WIN_LOG2'((1 << (WIN_LOG2-1)) - 1);
  localparam logic [WIN_LOG2-1:0] END_POS = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (tick) pos <= pos + 1'b1;
  end

  assign at_mid = (pos == MID_POS);
  assign at_end = (pos == END_POS);
endmodule

// File: rtl/bpsk31_bit_sequencer.sv
module bpsk31_bit_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic at_mid,
  input  logic at_end,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic cur_bit,
  output logic pol
);
  logic take_bit;
  logic flip_now;

  assign take_bit  = tick && at_end;
  assign flip_now  = tick && at_mid && !cur_bit;
  assign bit_ready = take_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bit <= 1'b0;
      pol     <= 1'b0;
    end else begin
      if (take_bit) cur_bit <= bit_valid ? bit_data : 1'b0;
      if (flip_now) pol     <= ~pol;
    end
  end
endmodule

// File: rtl/bpsk31_sample_mixer.sv
module bpsk31_sample_mixer
  import bpsk31_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [WIN_LOG2-1:0] pos,
  input  logic                cur_bit,
  input  logic                pol,
  output logic [ENV_W-1:0]    env_level,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_strobe
);
  logic                       rising_half;
  logic [RAMP_LOG2-1:0]       cycle_idx;
  logic [RAMP_LOG2-1:0]       level_idx;
  logic signed [SAMPLE_W-1:0] sine_val;
  logic [SAMPLE_W-1:0]        next_sample;

  assign rising_half = pos[WIN_LOG2-1];
  assign cycle_idx   = pos[WIN_LOG2-2:STEP_LOG2];
  assign level_idx   = rising_half ? cycle_idx : ~cycle_idx;

  always_comb begin
    env_level   = cur_bit ? ENV_FULL : env_at(level_idx);
    sine_val    = sine_at(pos[STEP_LOG2-1:0]);
    next_sample = mix(env_level, sine_val, pol);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_out    <= SAMPLE_W'(1 << (SAMPLE_W-1));
      sample_strobe <= 1'b0;
    end else begin
      sample_strobe <= tick;
      if (tick) sample_out <= next_sample;
    end
  end
endmodule

// File: rtl/bpsk31_shaper.sv
module bpsk31_shaper
  import bpsk31_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bit_valid,
  input  logic                bit_data,
  output logic                bit_ready,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_strobe
);
  logic [WIN_LOG2-1:0] pos;
  logic                at_mid;
  logic                at_end;
  logic                cur_bit;
  logic                pol;
  logic [ENV_W-1:0]    env_level;

  bpsk31_window_timer timer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pos(pos), .at_mid(at_mid), .at_end(at_end)
  );

  bpsk31_bit_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .at_mid(at_mid), .at_end(at_end),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .cur_bit(cur_bit), .pol(pol)
  );

  bpsk31_sample_mixer mixer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pos(pos), .cur_bit(cur_bit), .pol(pol),
    .env_level(env_level),
    .sample_out(sample_out), .sample_strobe(sample_strobe)
  );
endmodule

// File: rtl/bpsk31_shaper_chk.sv
module bpsk31_shaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic [7:0] sample_out,
  input logic       sample_strobe,
  input logic       at_mid,
  input logic       at_end,
  input logic       cur_bit,
  input logic       pol
);
  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sample_strobe);                                          // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !sample_strobe);                                        // R2
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sample_out));                                   // R2
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> (tick && at_end));                                  // R4
  AST_FLIP_ONLY_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol) |-> $past(tick && at_mid && !cur_bit));             // R5
  AST_ZERO_AT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_mid && !cur_bit) |=> (sample_out == 8'h80));          // R5
  AST_HOLD_POL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_mid && cur_bit) |=> $stable(pol));                    // R6
  AST_IDLE_REVERSAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_end && !bit_valid) |=> !cur_bit);                     // R7
endmodule

bind bpsk31_shaper bpsk31_shaper_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bit_valid(bit_valid),
  .bit_ready(bit_ready), .sample_out(sample_out), .sample_strobe(sample_strobe),
  .at_mid(at_mid), .at_end(at_end), .cur_bit(cur_bit), .pol(pol)
);

// File: tb/bpsk31_shaper_tb_top.sv
module bpsk31_shaper_tb_top;
  localparam real PI = 3.14159265358979;
  localparam int  NWIN = 6;
  // per window: {bit_valid, bit_data} offered for its accepting tick
  localparam logic [1:0] VEC [NWIN] = '{2'b11, 2'b10, 2'b00, 2'b11, 2'b11, 2'b10};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [7:0] sample_out;
  logic       sample_strobe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  int wpos = 0;
  int wbit = 0;
  int pol  = 0;
  int step = 0;
  int win_buf [1024];

  always #4 clk = ~clk;

  bpsk31_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready),
    .sample_out(sample_out), .sample_strobe(sample_strobe)
  );

  function automatic int rnd(input real v);
    return (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
  endfunction

  function automatic int sine_ref(input int i);
    return rnd(127.0 * $sin(2.0 * PI * (i + 0.5) / 32.0));
  endfunction

  function automatic int env_ref(input int k);
    real s;
    s = $sin(PI * (k + 0.5) / 32.0);
    return rnd(128.0 * s * s);
  endfunction

  function automatic int expect_sample(input int m, input int b, input int p, input int st);
    int e;
    int prod;
    if (b == 1)      e = 128;
    else if (m < 512) e = env_ref(15 - m / 32);
    else             e = env_ref((m - 512) / 32);
    prod = e * sine_ref(st % 32) * (p ? -1 : 1);
    return (128 + int'($floor(prod / 128.0 + 0.5))) & 255;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic v, input logic d, input bit full_chk);
    int exp;
    logic [7:0] held;
    tick = 1'b1; bit_valid = v; bit_data = d;
    #1;
    if (full_chk || wpos == 1023)
      check(bit_ready == (wpos == 1023), "R4 bit_ready", int'(bit_ready), int'(wpos == 1023));
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    exp = expect_sample(wpos, wbit, pol, step);
    check(sample_strobe == 1'b1, "R2 strobe after tick", int'(sample_strobe), 1);
    if (wbit == 1) check(int'(sample_out) == exp, "R6 full amplitude sample", int'(sample_out), exp);
    else           check(int'(sample_out) == exp, "R3/R5 shaped sample", int'(sample_out), exp);
    if (wbit == 0 && wpos == 511) check(sample_out == 8'h80, "R5 zero at flip", int'(sample_out), 8'h80);
    win_buf[wpos] = int'(sample_out);
    held = sample_out;
    // model update
    if (wpos == 511 && wbit == 0) pol = 1 - pol;
    step++;
    if (wpos == 1023) begin
      if (wbit == 0)
        for (int m = 0; m < 512; m++)
          if (win_buf[m] != win_buf[1023 - m]) begin
            check(1'b0, "R8 mirror", win_buf[m], win_buf[1023 - m]);
            break;
          end
      if (wbit == 0) check(1'b1, "R8 mirror", 0, 0);
      wpos = 0;
      wbit = v ? int'(d) : 0;
    end else wpos++;
    @(posedge clk); @(negedge clk);
    if (full_chk) begin
      check(sample_strobe == 1'b0, "R2 no strobe without tick", int'(sample_strobe), 0);
      check(sample_out == held, "R2 sample held", int'(sample_out), int'(held));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wpos = 0; wbit = 0; pol = 0; step = 0;
    @(negedge clk);
    check(sample_out == 8'h80, "R1 reset sample", int'(sample_out), 8'h80);
    check(sample_strobe == 1'b0, "R1 reset strobe", int'(sample_strobe), 0);
    check(bit_ready == 1'b0, "R1 reset ready", int'(bit_ready), 0);
  endtask

  initial begin
    do_reset();
    // window 0 is the reset-time idle reversal (R1, R7); VEC[k] governs window k+1
    for (int w = 0; w < NWIN; w++)
      for (int t = 0; t < 1024; t++)
        do_tick(VEC[w][1], VEC[w][0], (t % 128) == 0);
    // R9: carrier step and polarity continue across two no-reversal windows (VEC[3], VEC[4])
    check(step == NWIN * 1024, "R9 step count", step, NWIN * 1024);
    // directed: reset mid-window restores R1 state
    for (int t = 0; t < 300; t++) do_tick(1'b1, 1'b1, 1'b0);
    do_reset();
    // R7: no bit offered leaves the next window as a reversal, checked by the model
    for (int t = 0; t < 2048; t++) do_tick(1'b0, 1'b1, (t % 256) == 0);
    // R4: bit offered mid-window is not taken; only the boundary tick takes it
    for (int t = 0; t < 1024; t++) do_tick(1'b1, 1'b1, (t % 256) == 0);
    for (int t = 0; t < 1024; t++) do_tick(1'b0, 1'b0, (t % 256) == 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule